// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the 12-bit operand address of a memory-reference instruction in a word-addressed machine with a 4096-word memory split into 128-word pages. The instruction word carries a 7-bit offset inside a page and one page-select bit. With the select bit clear, the offset points into page zero. With it set, the offset points into the page that holds the instruction, taken from the upper five bits of that instruction's own program counter. The result drives the memory-address register's input bus.

The block also watches the resulting address for the auto-increment window, locations 010 to 017 octal (8 to 15). When the instruction asks for indirection and the address lies in that window, it raises a flag. A sequencer uses the flag to bump the pointer stored there before using it. The logic is purely combinational. Both outputs follow the instruction word and the program-counter input in the same cycle, with no register on the way.

Top module: `paged_ea_gen`

## Requirements
- R1: Address bits [6:0] equal instruction bits [6:0] (the in-page offset) for every input.
- R2: When instruction bit 7 (page select) is 0, address bits [11:7] are 0 (page zero).
- R3: When instruction bit 7 is 1, address bits [11:7] equal bits [11:7] of `exec_pc_i`, the program counter of the instruction being executed.
- R4: When instruction bit 8 (indirect) is 1 and the formed address is in 8..15 inclusive, `autoidx_o` is 1. This includes current-page addressing while the program counter is in page zero.
- R5: `autoidx_o` is 0 whenever the formed address is outside 8..15, including the neighbours 7 and 16 and any current-page address above page zero.
- R6: `autoidx_o` is 0 whenever instruction bit 8 is 0, whatever the address.
- R7: Instruction bits [11:9] have no effect on either output.
- R8: `exec_pc_i` bits [6:0] have no effect on either output, and outputs follow input changes with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 12 | Instruction word as read from memory |
| exec_pc_i | input | 12 | Program counter of the executing instruction (not incremented) |
| ea_o | output | 12 | Effective operand address toward the memory-address bus |
| autoidx_o | output | 1 | Indirect access into the auto-increment window |

## Verification
Both results are due in the same cycle as the inputs, because no register lies between any input and either output. The bench changes `instr_i` and `exec_pc_i` on the falling clock edge. It samples `ea_o` and `autoidx_o` one nanosecond later, well before the next rising edge, so each check compares the response to exactly one input pair. For the no-effect requirements, the bench applies a pair of vectors that differ only in the ignored bits and checks that the sampled outputs are identical.

// File: rtl/paged_ea_gen_pkg.sv
package paged_ea_gen_pkg;

  // default geometry of the addressing scheme
  localparam int unsigned EA_ADDR_W   = 12;
  localparam int unsigned EA_OFS_W    = 7;
  localparam int unsigned EA_WIN_BASE = 8;
  localparam int unsigned EA_WIN_SIZE = 8;

  // how the window detector is built
  typedef enum logic [0:0] {
    DET_RANGE = 1'b0,   // two magnitude compares
    DET_MASK  = 1'b1    // aligned power-of-two match on upper bits
  } det_style_e;

endpackage

// File: rtl/paged_ea_fields.sv
module paged_ea_fields #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OFS_W  = 7
) (
  input  logic [ADDR_W-1:0] instr_i,
  output logic [OFS_W-1:0]  offset_o,
  output logic              psel_o,
  output logic              indirect_o
);

  localparam int unsigned PSEL_POS = OFS_W;
  localparam int unsigned IND_POS  = OFS_W + 1;
  localparam int unsigned OP_LO    = OFS_W + 2;

  assign offset_o   = instr_i[OFS_W-1:0];
  assign psel_o     = instr_i[PSEL_POS];
  assign indirect_o = instr_i[IND_POS];

  // opcode bits belong to the decoder, not to address formation
  logic unused_opcode;
  assign unused_opcode = ^instr_i[ADDR_W-1:OP_LO];

endmodule

// File: rtl/paged_ea_page_mux.sv
module paged_ea_page_mux #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OFS_W  = 7
) (
  input  logic [ADDR_W-1:0] exec_pc_i,
  input  logic              psel_i,
  input  logic [OFS_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] page_base_o,
  output logic [ADDR_W-1:0] ea_o
);

  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  // base of the selected page: zero page or the executing instruction's page
  function automatic logic [ADDR_W-1:0] page_base(
    input logic [ADDR_W-1:0] pc,
    input logic              sel
  );
    logic [PAGE_W-1:0] pg;
    pg = sel ? pc[ADDR_W-1:OFS_W] : '0;
    return {pg, {OFS_W{1'b0}}};
  endfunction

  // offset lands in the low bits, which are zero in the base
  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [ADDR_W-1:0] base,
    input logic [OFS_W-1:0]  ofs
  );
    return base | {{PAGE_W{1'b0}}, ofs};
  endfunction

  assign page_base_o = page_base(exec_pc_i, psel_i);
  assign ea_o        = form_addr(page_base_o, offset_i);

  // in-page bits of the PC are replaced by the offset
  logic unused_pc_low;
  assign unused_pc_low = ^exec_pc_i[OFS_W-1:0];

endmodule

// File: rtl/paged_ea_autoidx_det.sv
module paged_ea_autoidx_det
  import paged_ea_gen_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WIN_BASE = 8,
  parameter int unsigned WIN_SIZE = 8,
  parameter det_style_e  STYLE    = DET_RANGE
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              indirect_i,
  output logic              in_window_o,
  output logic              hit_o
);

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(WIN_BASE + WIN_SIZE - 1);
  localparam logic [ADDR_W-1:0] KEEP_MSK = ~ADDR_W'(WIN_SIZE - 1);

  function automatic logic range_hit(input logic [ADDR_W-1:0] a);
    return (a >= LO_ADDR) && (a <= HI_ADDR);
  endfunction

  function automatic logic mask_hit(input logic [ADDR_W-1:0] a);
    return (a & KEEP_MSK) == LO_ADDR;
  endfunction

  generate
    if (STYLE == DET_MASK) begin : g_mask
      assign in_window_o = mask_hit(addr_i);
    end else begin : g_range
      assign in_window_o = range_hit(addr_i);
    end
  endgenerate

  assign hit_o = indirect_i & in_window_o;

endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import paged_ea_gen_pkg::*;
#(
  parameter int unsigned ADDR_W   = EA_ADDR_W,
  parameter int unsigned OFS_W    = EA_OFS_W,
  parameter int unsigned WIN_BASE = EA_WIN_BASE,
  parameter int unsigned WIN_SIZE = EA_WIN_SIZE,
  parameter det_style_e  STYLE    = DET_RANGE
) (
  input  logic [ADDR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0] exec_pc_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              autoidx_o
);

  // named internal events, visible to the checker
  logic [OFS_W-1:0]  offset_w;
  logic              psel_w;
  logic              indirect_w;
  logic [ADDR_W-1:0] page_base_w;
  logic [ADDR_W-1:0] ea_w;
  logic              window_w;
  logic              hit_w;

  paged_ea_fields #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_fields (
    .instr_i    (instr_i),
    .offset_o   (offset_w),
    .psel_o     (psel_w),
    .indirect_o (indirect_w)
  );

  paged_ea_page_mux #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_page (
    .exec_pc_i   (exec_pc_i),
    .psel_i      (psel_w),
    .offset_i    (offset_w),
    .page_base_o (page_base_w),
    .ea_o        (ea_w)
  );

  paged_ea_autoidx_det #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE), .STYLE(STYLE)
  ) u_det (
    .addr_i      (ea_w),
    .indirect_i  (indirect_w),
    .in_window_o (window_w),
    .hit_o       (hit_w)
  );

  assign ea_o      = ea_w;
  assign autoidx_o = hit_w;

endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned OFS_W    = 7,
  parameter int unsigned WIN_BASE = 8,
  parameter int unsigned WIN_SIZE = 8
) (
  input logic [ADDR_W-1:0] instr_i,
  input logic [ADDR_W-1:0] exec_pc_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              autoidx_o,
  input logic [ADDR_W-1:0] page_base_w,
  input logic              window_w
);

  localparam int unsigned LO = WIN_BASE;
  localparam int unsigned HI = WIN_BASE + WIN_SIZE - 1;

  always_comb begin
    p_offset_pass_r1: assert (ea_o[OFS_W-1:0] == instr_i[OFS_W-1:0])
      else $error("offset bits not passed through");
    if (!instr_i[OFS_W]) begin
      p_page_zero_r2: assert (ea_o[ADDR_W-1:OFS_W] == '0)
        else $error("page zero not selected");
    end
    if (instr_i[OFS_W]) begin
      p_cur_page_r3: assert (ea_o[ADDR_W-1:OFS_W] == exec_pc_i[ADDR_W-1:OFS_W])
        else $error("current page not selected");
    end
    p_base_low_zero_r3: assert (page_base_w[OFS_W-1:0] == '0)
      else $error("page base has in-page bits");
    if (instr_i[OFS_W+1] && (int'(ea_o) >= LO) && (int'(ea_o) <= HI)) begin
      p_flag_set_r4: assert (autoidx_o)
        else $error("auto-index flag missing");
    end
    if (autoidx_o) begin
      p_flag_in_window_r5: assert ((int'(ea_o) >= LO) && (int'(ea_o) <= HI) && window_w)
        else $error("auto-index flag outside window");
    end
    if (!instr_i[OFS_W+1]) begin
      p_flag_gated_r6: assert (!autoidx_o)
        else $error("auto-index flag without indirection");
    end
  end

endmodule

bind paged_ea_gen paged_ea_gen_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
) chk_i (
  .instr_i     (instr_i),
  .exec_pc_i   (exec_pc_i),
  .ea_o        (ea_o),
  .autoidx_o   (autoidx_o),
  .page_base_w (page_base_w),
  .window_w    (window_w)
);

// File: tb/paged_ea_gen_tb_top.sv
`timescale 1ns/1ps
module paged_ea_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] instr;
  logic [11:0] pc;
  logic [11:0] ea;
  logic        aix;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  paged_ea_gen dut_i (
    .instr_i   (instr),
    .exec_pc_i (pc),
    .ea_o      (ea),
    .autoidx_o (aix)
  );

  // expected address: arithmetic form, page number times 128 plus offset
  function automatic int exp_ea(input int ins, input int p);
    int page;
    page = ((ins / 128) % 2 == 1) ? (p / 128) : 0;
    return page * 128 + (ins % 128);
  endfunction

  function automatic bit exp_aix(input int ins, input int p);
    int a;
    a = exp_ea(ins, p);
    return ((ins / 256) % 2 == 1) && (a > 7) && (a < 16);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s instr=%o pc=%o got=%o exp=%o", req, instr, pc, got, exp);
    end
  endtask

  // apply on the falling edge, sample shortly after (no register in the path)
  task automatic apply(input int ins, input int p);
    @(negedge clk);
    instr = 12'(ins);
    pc    = 12'(p);
    #1;
  endtask

  task automatic vec(input string req, input int ins, input int p);
    apply(ins, p);
    chk({req, " ea"},  int'(ea),  exp_ea(ins, p));
    chk({req, " aix"}, int'(aix), int'(exp_aix(ins, p)));
  endtask

  initial begin
    int seed_unused;
    instr = '0;
    pc    = '0;
    seed_unused = $urandom(32'h5eed_0ea1);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset state: all-zero inputs give address 0, no flag (R1, R6)
    #1;
    chk("R1 reset ea", int'(ea), 0);
    chk("R6 reset aix", int'(aix), 0);

    // R1/R2: page zero, offset passes
    vec("R2", 12'o0123, 12'o7654);
    vec("R1", 12'o0177, 12'o0000);
    // R3: current page
    vec("R3", 12'o0245, 12'o7654);
    vec("R3", 12'o0200, 12'o7777);
    // R4: every window address with indirection, both page modes
    for (int a = 8; a < 16; a++) begin
      vec("R4", 256 + a, 12'o3456);
      vec("R4", 256 + 128 + a, 12'o0042);
    end
    // R5: window neighbours and window offsets in a higher page
    vec("R5", 256 + 7, 0);
    vec("R5", 256 + 16, 0);
    vec("R5", 256 + 128 + 10, 12'o0200);
    vec("R5", 256 + 128 + 12, 12'o3000);
    // R6: no indirection in window
    vec("R6", 10, 0);
    vec("R6", 128 + 15, 12'o0077);

    // R7: opcode bits ignored; R8: PC in-page bits ignored
    for (int k = 0; k < 40; k++) begin
      int ins, p, ea0, ax0;
      ins = int'($urandom_range(511, 0));
      p   = int'($urandom_range(4095, 0));
      apply(ins, p);
      ea0 = int'(ea);
      ax0 = int'(aix);
      apply(ins + 512 * int'($urandom_range(7, 1)), p);
      chk("R7 ea", int'(ea), ea0);
      chk("R7 aix", int'(aix), ax0);
      apply(ins, (p / 128) * 128 + int'($urandom_range(127, 0)));
      chk("R8 ea", int'(ea), ea0);
      chk("R8 aix", int'(aix), ax0);
    end

    // random mix, low offsets biased toward the window
    for (int k = 0; k < 3000; k++) begin
      int ins, p;
      ins = int'($urandom_range(4095, 0));
      if (k % 3 == 0) ins = (ins & ~127) | int'($urandom_range(17, 6));
      p = int'($urandom_range(4095, 0));
      if (k % 5 == 0) p = p % 128;
      vec("R1-R6 rand", ins, p);
      if (ins % 256 < 128) chk("R2 rand", int'(ea) / 128, 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule